// File: doc/BRIEF.md
# Serial Data Valid Monitor

This block watches a recovered serial stream that arrives one bit per clock, qualified by a bit-valid strobe. It decides whether the stream looks like well-formed 8B/10B Fibre Channel traffic and drives a registered flag, `data_valid`, that downstream logic can use to keep a bad source out of a loop. The judgement has two parts. A run check flags any stretch of identical bits that is longer than five. A comma check requires the positive-disparity comma fragment 0011111 to show up at least once in every window.

Counting only bits that arrive with the strobe high, the stream is cut into fixed windows of `WIN_BITS` bits (default 2^15). Errors found inside a window are held until that window ends. The flag changes only on the clock edge that accepts the last bit of a window. There it takes the verdict of the window that just closed: high if the window was clean, low if it held any error.

A mode input turns checking on and off. While the mode is off, the flag is held low and all tracking state is cleared. The first verdict after turning the mode on comes at the end of the first full window.

Top module: `dv_stream_monitor`

## Requirements
- R1: After reset and on the edge after `mode_en` goes low, `data_valid` is 0. Stored errors and the window bit count are cleared while `mode_en` is low.
- R2: A run of six or more consecutive identical bits causes `data_valid` to be 0 after the boundary of the window in which the sixth bit arrives. This applies to a run of 1s and to a run of 0s.
- R3: A run of exactly five identical bits is not an error.
- R4: A window in which the bit sequence 0011111 never ends gives `data_valid` = 0 after that window's boundary. The sequence is matched in arrival order, with the first received bit compared against the leftmost 0.
- R5: A window is `WIN_BITS` accepted bits long. `data_valid` changes only on the clock edge that accepts a window's last bit, and keeps its value for the rest of the window even when an error occurs mid-window.
- R6: A window with no run error that contains a comma gives `data_valid` = 1 at its boundary. A low flag returns high after one such clean window.
- R7: A cycle with `bit_vld` = 0 carries no bit. It does not advance the window count and does not enter the run or comma checks.
- R8: The run tracking and the comma matching continue across window boundaries. A comma whose last bit falls in a window counts for that window, even when its first bits arrived in the window before.
- R9: After `mode_en` rises, the first verdict is made on the edge that accepts the `WIN_BITS`-th valid bit, and not earlier.
- R10: Bits presented while `mode_en` is 0 are ignored. They do not count toward any window and cause no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_en | input | 1 | Checking enable, active high |
| bit_vld | input | 1 | High on cycles that carry a serial bit |
| bit_in | input | 1 | Serial data bit |
| data_valid | output | 1 | Registered verdict of the previous window, 1 for clean |

## Verification
The bench builds the block with `WIN_BITS` = 64 and keeps the run limit of five and the comma 0011111. The short window lets a single test drive many complete windows: clean windows, long runs of 1s and of 0s, a run of exactly five, comma-free traffic, strobe gaps, and a comma split across a boundary. It also brings mode changes in the middle of a window within reach, which tests that the count restarts and that bits sent while disabled are ignored. Mid-window samples show that the flag waits for the boundary, and boundary samples show the exact edge on which it moves.

// File: rtl/dvm_pkg.sv
package dvm_pkg;

    // Verdict carried by the data-valid flag
    typedef enum logic {
        VERDICT_BAD  = 1'b0,
        VERDICT_GOOD = 1'b1
    } verdict_e;

    // Per-bit findings handed from the detectors to the window judge
    typedef struct packed {
        logic run_err;
        logic comma_hit;
    } bit_findings_t;

endpackage

// File: rtl/run_length_check.sv
module run_length_check #(
    parameter int MAX_RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_vld,
    input  logic bit_in,
    output logic run_err
);
    localparam int CW = $clog2(MAX_RUN + 2);
    localparam logic [CW-1:0] RUN_LIMIT = CW'(MAX_RUN);
    localparam logic [CW-1:0] RUN_SAT   = CW'(MAX_RUN + 1);

    // run == 0 means no bit seen since enable
    typedef struct packed {
        logic          last_bit;
        logic [CW-1:0] run;
    } run_state_t;

    run_state_t q, d;
    logic       err_d;

    always_comb begin
        d     = q;
        err_d = 1'b0;
        if (!enable) begin
            d = '0;
        end else if (bit_vld) begin
            if (q.run != '0 && bit_in == q.last_bit) begin
                if (q.run < RUN_SAT) begin
                    d.run = q.run + 1'b1;
                end
            end else begin
                d.run = CW'(1);
            end
            d.last_bit = bit_in;
            err_d      = (d.run > RUN_LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_err = err_d;

    // R2
    run_err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_err |-> (bit_vld && enable));

    // R3
    run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run <= RUN_SAT);

endmodule

// File: rtl/comma_detect.sv
module comma_detect #(
    parameter int           PAT_W = 7,
    parameter logic [PAT_W-1:0] PAT = 7'b0011111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_vld,
    input  logic bit_in,
    output logic comma_hit
);
    localparam int FW = $clog2(PAT_W + 1);
    localparam logic [FW-1:0] FILL_FULL = FW'(PAT_W);

    // Oldest bit sits in the leftmost position
    typedef struct packed {
        logic [PAT_W-1:0] sr;
        logic [FW-1:0]    fill;
    } comma_state_t;

    comma_state_t     q, d;
    logic [PAT_W-1:0] bit_match;

    always_comb begin
        d = q;
        if (!enable) begin
            d = '0;
        end else if (bit_vld) begin
            d.sr = {q.sr[PAT_W-2:0], bit_in};
            if (q.fill < FILL_FULL) begin
                d.fill = q.fill + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < PAT_W; i++) begin : g_match
        assign bit_match[i] = ~(d.sr[i] ^ PAT[i]);
    end

    assign comma_hit = enable && bit_vld && (d.fill == FILL_FULL) && (&bit_match);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4
    comma_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comma_hit |-> (bit_vld && bit_in == PAT[0]));

    // R4
    comma_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comma_hit |-> (q.fill >= FW'(PAT_W - 1)));

endmodule

// File: rtl/window_judge.sv
module window_judge
    import dvm_pkg::*;
#(
    parameter int WIN_BITS = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          bit_vld,
    input  bit_findings_t found,
    output logic          data_valid
);
    localparam int CW = (WIN_BITS > 2) ? $clog2(WIN_BITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run_seen;
        logic          comma_seen;
        verdict_e      dv;
    } judge_state_t;

    judge_state_t q, d;
    logic         win_end;

    always_comb begin
        d       = q;
        win_end = 1'b0;
        if (!enable) begin
            d = '0;
        end else if (bit_vld) begin
            win_end = (q.cnt == LAST);
            if (win_end) begin
                d.cnt        = '0;
                d.run_seen   = 1'b0;
                d.comma_seen = 1'b0;
                d.dv = (!(q.run_seen || found.run_err) && (q.comma_seen || found.comma_hit))
                       ? VERDICT_GOOD : VERDICT_BAD;
            end else begin
                d.cnt        = q.cnt + 1'b1;
                d.run_seen   = q.run_seen   || found.run_err;
                d.comma_seen = q.comma_seen || found.comma_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_valid = (q.dv == VERDICT_GOOD);

    // R5
    win_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LAST);

    // R5
    dv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(bit_vld && q.cnt == LAST)) |=> $stable(data_valid));

    // R1
    dv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!data_valid && q.cnt == '0));

    // R7
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_vld) |=> $stable(q.cnt));

endmodule

// File: rtl/dv_stream_monitor.sv
module dv_stream_monitor
    import dvm_pkg::*;
#(
    parameter int               WIN_BITS = 32768,
    parameter int               MAX_RUN  = 5,
    parameter int               PAT_W    = 7,
    parameter logic [PAT_W-1:0] PAT      = 7'b0011111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic data_valid
);
    bit_findings_t found;

    run_length_check #(
        .MAX_RUN (MAX_RUN)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode_en),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .run_err (found.run_err)
    );

    comma_detect #(
        .PAT_W (PAT_W),
        .PAT   (PAT)
    ) u_comma (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode_en),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .comma_hit (found.comma_hit)
    );

    window_judge #(
        .WIN_BITS (WIN_BITS)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (mode_en),
        .bit_vld    (bit_vld),
        .found      (found),
        .data_valid (data_valid)
    );

endmodule

// File: tb/tb_dv_stream_monitor.sv
`timescale 1ns/1ps
module tb_dv_stream_monitor;
    localparam int WIN = 64;

    // 64-bit window images, sent MSB first
    localparam logic [63:0] CLEAN   = 64'h3E3E3E3E3E3E3E3E; // commas, runs <= 5
    localparam logic [63:0] ONES6   = 64'h3F3E3E3E3E3E3E3E; // six 1s early
    localparam logic [63:0] ZEROS6  = 64'h3E3E3E813E3E3E3E; // six 0s
    localparam logic [63:0] ZEROS5  = 64'h3E3E3E413E3E3E3E; // five 0s only
    localparam logic [63:0] ALT     = 64'hAAAAAAAAAAAAAAAA; // no comma
    localparam logic [63:0] STRAD_A = 64'h3E3E3E3E3E3E3E51; // ends 001
    localparam logic [63:0] STRAD_B = 64'hF555555555555555; // starts 1111, no own comma

    logic clk = 1'b0;
    logic rst_n, mode_en, bit_vld, bit_in;
    logic data_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    dv_stream_monitor #(.WIN_BITS(WIN)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .bit_vld    (bit_vld),
        .bit_in     (bit_in),
        .data_valid (data_valid)
    );

    always #4 clk = ~clk;

    task automatic compare(input logic act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: data_valid actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_now(input bit exp, input string tag);
        @(negedge clk);
        bit_vld = 1'b0;
        compare(data_valid, exp, tag);
    endtask

    task automatic send_bit(input logic b, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_vld = 1'b0;
        end
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(posedge clk);
    endtask

    task automatic send_range(input logic [63:0] v, input int hi, input int lo, input int gap);
        for (int i = hi; i >= lo; i--) begin
            send_bit(v[i], gap);
        end
    endtask

    // Driver side of the scoreboard: expected verdict after a boundary edge
    task automatic push_exp(input bit e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic send_window(input logic [63:0] v, input int gap, input bit e, input string tag);
        send_range(v, 63, 0, gap);
        push_exp(e, tag);
    endtask

    // Monitor side: sample after the boundary edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            compare(data_valid, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        mode_en = 1'b0;
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        repeat (4) @(negedge clk);
        compare(data_valid, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        compare(data_valid, 1'b0, "R1 after reset");

        mode_en = 1'b1;
        // First window: no verdict midway
        send_range(CLEAN, 63, 32, 0);
        check_now(1'b0, "R9 mid first window");
        send_range(CLEAN, 31, 0, 0);
        push_exp(1'b1, "R6 first clean window");
        check_now(1'b1, "R5 boundary edge");

        // Error early, flag holds until boundary
        send_range(ONES6, 63, 32, 0);
        check_now(1'b1, "R5 hold mid window");
        send_range(ONES6, 31, 0, 0);
        push_exp(1'b0, "R2 six ones");

        send_window(CLEAN,  0, 1'b1, "R6 recovery after one clean window");
        send_window(ZEROS6, 0, 1'b0, "R2 six zeros");
        send_window(ZEROS5, 0, 1'b1, "R3 run of five");
        send_window(ALT,    0, 1'b0, "R4 no comma");

        // Strobe gaps do not count as bits
        send_range(CLEAN, 63, 24, 2);
        check_now(1'b0, "R7 gaps do not advance window");
        send_range(CLEAN, 23, 0, 2);
        push_exp(1'b1, "R7 clean window with gaps");

        send_window(STRAD_A, 0, 1'b1, "R8 window before split comma");
        send_window(STRAD_B, 0, 1'b1, "R8 split comma counts in later window");

        // Partial window, then disable
        send_range(ALT, 63, 44, 0);
        @(negedge clk);
        mode_en = 1'b0;
        bit_vld = 1'b0;
        check_now(1'b0, "R1 low after disable");
        send_range(ONES6, 63, 0, 0);
        check_now(1'b0, "R10 bits ignored while disabled");

        @(negedge clk);
        mode_en = 1'b1;
        bit_vld = 1'b0;
        send_range(CLEAN, 63, 20, 0);
        check_now(1'b0, "R9 count restarted on enable");
        send_range(CLEAN, 19, 0, 0);
        push_exp(1'b1, "R9 first verdict after full window");

        send_window(ALT, 0, 1'b0, "R4 no comma again");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule